// File: doc/BRIEF.md
# SD Card SPI Data Block Engine

This block runs the data phase of a block read or block write on an SD card in SPI mode, after the command has already been issued elsewhere. It does not shift bits itself. It asks an external byte shifter for one full-duplex byte exchange at a time and handles everything above that level: start tokens, payload byte counting, the 16-bit CRC on each block, the data-response token after a write, and the busy wait that follows it.

On a read, the engine polls the card with 0xFF bytes until the start token arrives. It then passes the payload out on a byte port with a one-cycle valid strobe, reads the two trailing CRC bytes and compares them with its own CRC. On a write, it sends the start token and then takes the payload from a valid/ready byte input. It appends the CRC, waits for the card's data-response token, and polls until the card stops holding the line low. Several blocks can be moved in one run. Each block has its own token and its own CRC, and on a write each block has its own response.

Top module: `sd_spi_blk_engine`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle. In read mode every byte the engine transmits is 0xFF. In write mode the first byte transmitted is the start token 0xFE.
- R2: In read mode, every received byte other than 0xFE before the token counts as filler. After 0xFE, the next block-length received bytes appear in order on `rd_data`, each with a one-cycle `rd_valid`.
- R3: The two bytes after a read payload are taken as a CRC, high byte first, and compared with CRC16 (polynomial 0x1021, initial value 0, MSB first) over that block's payload. A mismatch sets `crc_error`, which stays set for the rest of the run.
- R4: In write mode, each payload byte is taken from `wr_data` in a cycle where both `wr_valid` and `wr_ready` are high, and is transmitted in order after the 0xFE token. The block's CRC16 follows, high byte first.
- R5: After a written block's CRC, the engine polls with 0xFF until it receives a byte with bit 4 = 0 and bit 0 = 1. If bits 3:1 equal 010 the block is accepted. Any other value sets `write_error` and ends the run with no busy polling.
- R6: After an accepted block, the engine keeps polling until it receives a nonzero byte. Only then does it go to the next block, or pulse `done` for one cycle.
- R7: If 1024 bytes are polled without the token (on a read) or without a matching response (on a write), `timeout_error` is set and the run ends with `done`. A token arriving on the 1024th poll is still accepted.
- R8: A block length of 0 is used as 1, and a length above 512 is used as 512. A block count of 0 is used as 1. In a multi-block run, every block has its own token and CRC, and on a write its own response and busy wait.
- R9: The error flags are cleared by an accepted `start` and are held after `done` until the next one. A `start` pulse while busy is ignored.
- R10: `xfer_req` is a single-cycle pulse, and no new request is made until `xfer_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a data phase (sampled only when idle) |
| write_mode | input | 1 | 1 = write blocks, 0 = read blocks |
| blk_len | input | 10 | Bytes per block, 1 to 512 |
| blk_num | input | 8 | Number of blocks in the run |
| xfer_req | output | 1 | Request one byte exchange from the shifter |
| xfer_tx | output | 8 | Byte to transmit, valid with `xfer_req` |
| xfer_done | input | 1 | Shifter finished the exchange |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | `wr_data` is available |
| wr_ready | output | 1 | Engine can take a payload byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| crc_error | output | 1 | A read block failed its CRC check |
| write_error | output | 1 | A written block was rejected |
| timeout_error | output | 1 | Token or response never arrived |

## Verification
A wrong byte count or wrong token state shows up at once in the sequence of transmitted bytes and in the number of exchanges before `done`. So the bench logs every exchange and compares the whole sequence and its length. A corrupted CRC register surfaces at the end of the block: on a read as a wrongly raised or missing `crc_error`, on a write as wrong CRC bytes in the log. A stuck wait counter shows either as a timeout that fires on a card that would have answered in time, or as one that never fires, so the bench probes the 1024-poll boundary from both sides.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

    localparam logic [7:0] TOK_START = 8'hFE;
    localparam logic [7:0] BYTE_FILL = 8'hFF;
    localparam logic [2:0] RESP_OK   = 3'b010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_R_WAIT,
        ST_R_DATA,
        ST_R_CRC_HI,
        ST_R_CRC_LO,
        ST_W_TOKEN,
        ST_W_DATA,
        ST_W_CRC_HI,
        ST_W_CRC_LO,
        ST_W_RESP,
        ST_W_BUSY,
        ST_FINISH
    } blk_state_e;

    typedef struct packed {
        logic crc_bad;
        logic wr_rej;
        logic tmo;
    } blk_err_s;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic is_resp_token(input logic [7:0] b);
        return (b[4] == 1'b0) && (b[0] == 1'b1);
    endfunction

endpackage

// File: rtl/sdblk_crc16.sv
module sdblk_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import sdblk_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 16'h0000;
        end else if (en) begin
            crc <= crc16_step(crc, din);
        end
    end
endmodule

// File: rtl/sdblk_dncnt.sv
module sdblk_dncnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign is_last = (cnt == W'(1));
endmodule

// File: rtl/sdblk_waitcnt.sv
module sdblk_waitcnt #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expire = inc && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sd_spi_blk_engine.sv
module sd_spi_blk_engine #(
    parameter int MAX_LEN    = 512,
    parameter int LEN_W      = $clog2(MAX_LEN + 1),
    parameter int NUM_W      = 8,
    parameter int WAIT_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             write_mode,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [NUM_W-1:0] blk_num,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             busy,
    output logic             done,
    output logic             crc_error,
    output logic             write_error,
    output logic             timeout_error
);
    import sdblk_pkg::*;

    blk_state_e       st;
    logic             pend;
    blk_err_s         errs;
    logic [7:0]       crc_hi_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] eff_len;
    logic [NUM_W-1:0] eff_num;
    logic [15:0]      crc;

    logic start_go, xchg_state, issue, ev, wr_take;
    logic byte_last, blk_last, wait_expire;
    logic blk_end, byte_dec, wait_clr, wait_inc;
    logic crc_clr, crc_en, resp_hit;
    logic [7:0] crc_din;

    // effective length and block count
    always_comb begin
        if (blk_len == '0)                        eff_len = LEN_W'(1);
        else if (blk_len > LEN_W'(MAX_LEN))       eff_len = LEN_W'(MAX_LEN);
        else                                      eff_len = blk_len;
        eff_num = (blk_num == '0) ? NUM_W'(1) : blk_num;
    end

    assign start_go   = start && (st == ST_IDLE);
    assign xchg_state = (st != ST_IDLE) && (st != ST_FINISH);
    assign issue      = !pend && xchg_state && ((st != ST_W_DATA) || wr_valid);
    assign ev         = pend && xfer_done;
    assign wr_ready   = (st == ST_W_DATA) && !pend;
    assign wr_take    = wr_ready && wr_valid;
    assign resp_hit   = is_resp_token(xfer_rx);

    assign xfer_req = issue;
    always_comb begin
        case (st)
            ST_W_TOKEN:  xfer_tx = TOK_START;
            ST_W_DATA:   xfer_tx = wr_data;
            ST_W_CRC_HI: xfer_tx = crc[15:8];
            ST_W_CRC_LO: xfer_tx = crc[7:0];
            default:     xfer_tx = BYTE_FILL;
        endcase
    end

    assign blk_end  = ev && ((st == ST_R_CRC_LO) || (st == ST_W_BUSY && xfer_rx != 8'h00));
    assign byte_dec = ev && ((st == ST_R_DATA) || (st == ST_W_DATA));
    assign wait_inc = ev && (((st == ST_R_WAIT) && (xfer_rx != TOK_START)) ||
                             ((st == ST_W_RESP) && !resp_hit));
    assign wait_clr = start_go || blk_end ||
                      (ev && (st == ST_R_WAIT) && (xfer_rx == TOK_START)) ||
                      (ev && (st == ST_W_RESP) && resp_hit);
    assign crc_clr  = start_go || blk_end;
    assign crc_en   = (ev && (st == ST_R_DATA)) || wr_take;
    assign crc_din  = (st == ST_R_DATA) ? xfer_rx : wr_data;

    sdblk_crc16 crc_i (
        .clk (clk), .rst (rst), .clr (crc_clr), .en (crc_en),
        .din (crc_din), .crc (crc)
    );

    sdblk_dncnt #(.W(LEN_W)) bytecnt_i (
        .clk (clk), .rst (rst), .load (start_go || blk_end),
        .load_val (start_go ? eff_len : len_q),
        .dec (byte_dec), .is_last (byte_last)
    );

    sdblk_dncnt #(.W(NUM_W)) blkcnt_i (
        .clk (clk), .rst (rst), .load (start_go), .load_val (eff_num),
        .dec (blk_end), .is_last (blk_last)
    );

    sdblk_waitcnt #(.LIMIT(WAIT_LIMIT)) waitcnt_i (
        .clk (clk), .rst (rst), .clr (wait_clr), .inc (wait_inc),
        .expire (wait_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pend     <= 1'b0;
            errs     <= '0;
            crc_hi_q <= 8'h00;
            len_q    <= '0;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (issue)   pend <= 1'b1;
            else if (ev) pend <= 1'b0;

            case (st)
                ST_IDLE: begin
                    if (start_go) begin
                        errs  <= '0;
                        len_q <= eff_len;
                        st    <= write_mode ? ST_W_TOKEN : ST_R_WAIT;
                    end
                end
                ST_R_WAIT: if (ev) begin
                    if (xfer_rx == TOK_START) begin
                        st <= ST_R_DATA;
                    end else if (wait_expire) begin
                        errs.tmo <= 1'b1;
                        st       <= ST_FINISH;
                    end
                end
                ST_R_DATA: if (ev) begin
                    rd_data  <= xfer_rx;
                    rd_valid <= 1'b1;
                    if (byte_last) st <= ST_R_CRC_HI;
                end
                ST_R_CRC_HI: if (ev) begin
                    crc_hi_q <= xfer_rx;
                    st       <= ST_R_CRC_LO;
                end
                ST_R_CRC_LO: if (ev) begin
                    if ({crc_hi_q, xfer_rx} != crc) errs.crc_bad <= 1'b1;
                    st <= blk_last ? ST_FINISH : ST_R_WAIT;
                end
                ST_W_TOKEN:  if (ev) st <= ST_W_DATA;
                ST_W_DATA:   if (ev && byte_last) st <= ST_W_CRC_HI;
                ST_W_CRC_HI: if (ev) st <= ST_W_CRC_LO;
                ST_W_CRC_LO: if (ev) st <= ST_W_RESP;
                ST_W_RESP: if (ev) begin
                    if (resp_hit) begin
                        if (xfer_rx[3:1] == RESP_OK) begin
                            st <= ST_W_BUSY;
                        end else begin
                            errs.wr_rej <= 1'b1;
                            st          <= ST_FINISH;
                        end
                    end else if (wait_expire) begin
                        errs.tmo <= 1'b1;
                        st       <= ST_FINISH;
                    end
                end
                ST_W_BUSY: if (blk_end) begin
                    st <= blk_last ? ST_FINISH : ST_W_TOKEN;
                end
                ST_FINISH: st <= ST_IDLE;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (st != ST_IDLE);
    assign done          = (st == ST_FINISH);
    assign crc_error     = errs.crc_bad;
    assign write_error   = errs.wr_rej;
    assign timeout_error = errs.tmo;

endmodule

// File: rtl/sdblk_checker.sv
module sdblk_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       xfer_req,
    input logic [7:0] xfer_tx,
    input logic       xfer_done,
    input logic       rd_valid,
    input logic       wr_ready,
    input logic       wr_valid,
    input logic [7:0] wr_data,
    input logic       crc_error,
    input logic       write_error,
    input logic       timeout_error
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                                   // R1
    AST_RDVALID_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);                                           // R2
    AST_WR_TAKE_SENT: assert property (@(posedge clk) disable iff (rst)
        (wr_ready && wr_valid) |-> (xfer_req && xfer_tx == wr_data)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R6
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({crc_error, write_error, timeout_error})); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        xfer_req |=> !xfer_req);                                      // R10
    AST_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=> (!xfer_req || $past(xfer_done) || xfer_done)); // R10
endmodule

bind sd_spi_blk_engine sdblk_checker chk_i (
    .clk (clk), .rst (rst), .start (start), .busy (busy), .done (done),
    .xfer_req (xfer_req), .xfer_tx (xfer_tx), .xfer_done (xfer_done),
    .rd_valid (rd_valid), .wr_ready (wr_ready), .wr_valid (wr_valid),
    .wr_data (wr_data), .crc_error (crc_error), .write_error (write_error),
    .timeout_error (timeout_error)
);

// File: tb/sd_spi_blk_engine_tb_top.sv
`timescale 1ns/1ps
module sd_spi_blk_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       write_mode = 1'b0;
    logic [9:0] blk_len = 10'd1;
    logic [7:0] blk_num = 8'd1;
    logic       xfer_req;
    logic [7:0] xfer_tx;
    logic       xfer_done;
    logic [7:0] xfer_rx;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] wr_data;
    logic       wr_valid = 1'b1;
    logic       wr_ready;
    logic       busy, done, crc_error, write_error, timeout_error;

    always #4 clk = ~clk;   // 125 MHz

    sd_spi_blk_engine dut_i (
        .clk (clk), .rst (rst), .start (start), .write_mode (write_mode),
        .blk_len (blk_len), .blk_num (blk_num),
        .xfer_req (xfer_req), .xfer_tx (xfer_tx), .xfer_done (xfer_done),
        .xfer_rx (xfer_rx), .rd_data (rd_data), .rd_valid (rd_valid),
        .wr_data (wr_data), .wr_valid (wr_valid), .wr_ready (wr_ready),
        .busy (busy), .done (done), .crc_error (crc_error),
        .write_error (write_error), .timeout_error (timeout_error)
    );

    logic [7:0] rx_script [0:2047];
    logic [7:0] tx_log    [0:2047];
    logic [7:0] rd_log    [0:1023];
    logic [7:0] pay       [0:1023];
    int tx_n, rx_i, rd_n, wr_i, dly;
    logic log_clr = 1'b0;
    int errors = 0;
    int checks = 0;
    int cyc = 0;

    assign wr_data = pay[wr_i];

    // byte shifter and card model: fixed latency per exchange
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (rst || log_clr) begin
            dly <= 0; tx_n <= 0; rx_i <= 0; rd_n <= 0; wr_i <= 0;
            xfer_rx <= 8'hFF;
        end else begin
            if (xfer_req) begin
                tx_log[tx_n] <= xfer_tx;
                tx_n <= tx_n + 1;
                dly  <= 3;
            end else if (dly > 0) begin
                dly <= dly - 1;
                if (dly == 1) begin
                    xfer_done <= 1'b1;
                    xfer_rx   <= rx_script[rx_i];
                    rx_i      <= rx_i + 1;
                end
            end
            if (wr_valid && wr_ready) wr_i <= wr_i + 1;
            if (rd_valid) begin
                rd_log[rd_n] <= rd_data;
                rd_n <= rd_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, act=%0d exp=<190000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic logic [15:0] ref_crc(input int base, input int n);
        logic [15:0] c;
        c = 16'h0;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ pay[base + k][b];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic prep(input int seed);
        for (int i = 0; i < 2048; i++) rx_script[i] = 8'hFF;
        for (int i = 0; i < 1024; i++) pay[i] = 8'((i * 37 + seed) ^ (i >> 3));
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
    endtask

    task automatic launch(input logic wm, input int len, input int num);
        write_mode = wm;
        blk_len    = 10'(len);
        blk_num    = 8'(num);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {req, " done seen"}, int'(done), 1);
        @(negedge clk);
    endtask

    // place a read block into the card script at position p; returns next position
    task automatic put_rd_block(inout int p, input int base, input int len, input logic bad);
        logic [15:0] c;
        c = ref_crc(base, len);
        if (bad) c = c ^ 16'h0001;
        rx_script[p] = 8'hFE; p++;
        for (int k = 0; k < len; k++) begin rx_script[p] = pay[base + k]; p++; end
        rx_script[p] = c[15:8]; p++;
        rx_script[p] = c[7:0];  p++;
    endtask

    task automatic t_reset;
        check(busy == 0 && done == 0 && xfer_req == 0, "R9 reset idle", int'({busy, done, xfer_req}), 0);
        check({crc_error, write_error, timeout_error} == 3'b000, "R9 reset flags",
              int'({crc_error, write_error, timeout_error}), 0);
    endtask

    task automatic t_read_single;
        int p;
        logic all_ff;
        prep(3);
        p = 2;
        put_rd_block(p, 0, 4, 1'b0);
        launch(1'b0, 4, 1);
        check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        wait_done("R2");
        check(rd_n == 4, "R2 read byte count", rd_n, 4);
        for (int k = 0; k < 4; k++)
            check(rd_log[k] == pay[k], "R2 read byte value", int'(rd_log[k]), int'(pay[k]));
        check(crc_error == 0, "R3 good crc", int'(crc_error), 0);
        check(tx_n == 9, "R2 exchange count", tx_n, 9);
        all_ff = 1'b1;
        for (int k = 0; k < 9; k++) if (tx_log[k] != 8'hFF) all_ff = 1'b0;
        check(all_ff, "R1 read sends only 0xFF", int'(all_ff), 1);
    endtask

    task automatic t_read_badcrc;
        int p;
        prep(9);
        p = 0;
        put_rd_block(p, 0, 5, 1'b1);
        launch(1'b0, 5, 1);
        wait_done("R3");
        check(crc_error == 1, "R3 crc mismatch flagged", int'(crc_error), 1);
        repeat (5) @(negedge clk);
        check(crc_error == 1, "R9 flag held after done", int'(crc_error), 1);
    endtask

    task automatic t_read_timeout;
        prep(1);
        launch(1'b0, 8, 1);
        wait_done("R7");
        check(timeout_error == 1, "R7 timeout flagged", int'(timeout_error), 1);
        check(tx_n == 1024, "R7 polls before timeout", tx_n, 1024);
        check(rd_n == 0, "R7 no data on timeout", rd_n, 0);
        check(crc_error == 0, "R9 crc flag cleared by start", int'(crc_error), 0);
    endtask

    task automatic t_read_late_token;
        int p;
        prep(5);
        p = 1023;
        put_rd_block(p, 0, 2, 1'b0);
        launch(1'b0, 2, 1);
        wait_done("R7");
        check(timeout_error == 0, "R7 token on 1024th poll accepted", int'(timeout_error), 0);
        check(rd_n == 2, "R7 late token data count", rd_n, 2);
    endtask

    task automatic t_read_lengths;
        int p;
        prep(11);
        p = 0;
        put_rd_block(p, 0, 1, 1'b0);
        launch(1'b0, 0, 1);
        wait_done("R8");
        check(rd_n == 1 && tx_n == 4, "R8 length 0 used as 1", rd_n * 16 + tx_n, 1 * 16 + 4);
        prep(12);
        p = 0;
        put_rd_block(p, 0, 512, 1'b0);
        launch(1'b0, 600, 1);
        wait_done("R8");
        check(rd_n == 512, "R8 length above 512 clamped", rd_n, 512);
        check(crc_error == 0, "R8 clamped block crc", int'(crc_error), 0);
    endtask

    task automatic t_read_multi;
        int p;
        prep(21);
        p = 0;
        put_rd_block(p, 0, 2, 1'b0);
        rx_script[p] = 8'hFF; p++;
        put_rd_block(p, 2, 2, 1'b1);
        launch(1'b0, 2, 2);
        wait_done("R8");
        check(rd_n == 4, "R8 multi read byte count", rd_n, 4);
        check(rd_log[3] == pay[3], "R8 multi read second block", int'(rd_log[3]), int'(pay[3]));
        check(crc_error == 1, "R3 second block crc checked", int'(crc_error), 1);
    endtask

    task automatic t_write_single;
        logic [15:0] c;
        prep(7);
        rx_script[7]  = 8'hE5;   // bit4=0 bit0=1 status 010
        rx_script[8]  = 8'h00;
        rx_script[9]  = 8'h00;
        rx_script[10] = 8'hFF;
        c = ref_crc(0, 3);
        launch(1'b1, 3, 1);
        wait_done("R6");
        check(tx_log[0] == 8'hFE, "R1 write starts with token", int'(tx_log[0]), 'hFE);
        for (int k = 0; k < 3; k++)
            check(tx_log[1 + k] == pay[k], "R4 payload byte sent", int'(tx_log[1 + k]), int'(pay[k]));
        check({tx_log[4], tx_log[5]} == c, "R4 crc bytes high first", int'({tx_log[4], tx_log[5]}), int'(c));
        check(tx_n == 11, "R6 busy polled until nonzero", tx_n, 11);
        check(write_error == 0 && timeout_error == 0, "R5 accepted write",
              int'({write_error, timeout_error}), 0);
    endtask

    task automatic t_write_reject;
        prep(8);
        rx_script[6] = 8'h0B;    // status 101
        rx_script[7] = 8'h00;
        launch(1'b1, 3, 1);
        wait_done("R5");
        check(write_error == 1, "R5 rejected write flagged", int'(write_error), 1);
        check(tx_n == 7, "R5 no busy poll after reject", tx_n, 7);
    endtask

    task automatic t_write_multi;
        logic [15:0] c1;
        prep(15);
        rx_script[5]  = 8'hE5;
        rx_script[12] = 8'hE5;
        c1 = ref_crc(2, 2);
        launch(1'b1, 2, 2);
        wait_done("R8");
        check(tx_n == 14, "R8 multi write exchange count", tx_n, 14);
        check(tx_log[7] == 8'hFE, "R8 second block token", int'(tx_log[7]), 'hFE);
        check({tx_log[10], tx_log[11]} == c1, "R8 second block own crc",
              int'({tx_log[10], tx_log[11]}), int'(c1));
    endtask

    task automatic t_start_ignored;
        int p;
        prep(30);
        p = 3;
        put_rd_block(p, 0, 3, 1'b0);
        launch(1'b0, 3, 1);
        repeat (4) @(negedge clk);
        write_mode = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done("R9");
        check(rd_n == 3 && tx_n == 9, "R9 start while busy ignored", rd_n * 16 + tx_n, 3 * 16 + 9);
        check(tx_log[0] == 8'hFF, "R9 run stayed a read", int'(tx_log[0]), 'hFF);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) rx_script[i] = 8'hFF;
        for (int i = 0; i < 1024; i++) pay[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_single();
        t_read_badcrc();
        t_read_timeout();
        t_read_late_token();
        t_read_lengths();
        t_read_multi();
        t_write_single();
        t_write_reject();
        t_write_multi();
        t_start_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule